// File: doc/BRIEF.md
# Converter power-mode controller

This block is the power and clock-mode sequencer that sits beside a serial analog-to-digital converter core. It receives each control byte as a single-cycle request carrying the two power/clock mode bits. It also takes the sensed state of a three-level shutdown pin, given as a low flag and a high flag, where neither flag set means the pin is floating. A pulse from the converter core marks the end of each conversion. From these it decides when a conversion may start, whether the part stays powered afterwards, which clock mode the converter runs in, and which reference-compensation scheme is in force.

After reset the controller holds conversions off for a power-on interval, running in internal clock mode with the ready strobe high. A software power-down request lets the current conversion finish before the part drops into fast or full power-down. The next control byte then wakes the part, and the conversion it asks for starts once a wake-up delay has run out. The delay depends on the power-down depth and on the compensation mode. Pulling the shutdown pin low cancels any running conversion at once and forces full power-down, whatever the mode bits say. All delays come from a microsecond timer whose prescale is a parameter.

Top module: `conv_pwr_ctrl`

## Requirements
- R1: After reset the block reports a power-up wait: `wakeUp`=1 and `powerOn`, `fastDown`, `fullDown`, `converting`, `busy` and `extClk` are all 0, with `convStrobe`=1.
- R2: No conversion starts during the power-on interval of POR_US microseconds. That interval is POR_US*CLK_PER_US cycles after reset release, and the state changes on the following edge. A request arriving in the interval sets `busy` and starts its conversion when the interval ends.
- R3: `doutEn` stays 0 from reset until the first completed conversion (`convDone` while converting). From then on it stays 1.
- R4: The mode bits are decoded as follows. `reqPd[1]`=1 keeps the part powered after the conversion, and `reqPd[0]` then selects the clock mode (1 = external, 0 = internal). `reqPd[1]`=0 sends the part into power-down when the conversion completes: fast power-down if `reqPd[0]`=1, full power-down if `reqPd[0]`=0.
- R5: While a conversion runs, further requests are ignored: `converting` stays 1 and `extClk` keeps its value. A power-down request leaves `extClk` at its last value.
- R6: A request in fast or full power-down raises `busy` and `wakeUp`. The request's conversion starts after the wake delay: FAST_WAKE_US from fast power-down with internal compensation, FULL_WAKE_US from full power-down with internal compensation, and EXT_WAKE_US from either depth with external compensation.
- R7: Once the shutdown pin reads low through the two-flop synchroniser, the next edge forces full power-down (`fullDown`=1). Any running conversion stops, and a one-cycle `convAbort` pulse marks that case. Pending requests are dropped, and requests are ignored while the pin stays low.
- R8: `compInt` is 1 when the synchronised pin reads high and 0 when it floats (external compensation).
- R9: When the shutdown pin is released, the block waits the full power-down wake delay and then returns to powered idle without converting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle strobe: start bit plus control byte received |
| reqPd | input | 2 | Power/clock mode bits of that control byte |
| convDone | input | 1 | One-cycle pulse from the converter core at end of conversion |
| pinLow | input | 1 | Shutdown pin sensed low |
| pinHigh | input | 1 | Shutdown pin sensed high (neither flag set means floating) |
| powerOn | output | 1 | Powered and idle or converting |
| fastDown | output | 1 | In fast power-down |
| fullDown | output | 1 | In full power-down (software or pin) |
| wakeUp | output | 1 | Power-on or wake delay running |
| busy | output | 1 | A conversion request is held off by a delay |
| converting | output | 1 | Conversion in progress |
| convStrobe | output | 1 | Ready strobe, low while converting |
| extClk | output | 1 | Active clock mode, 1 = external |
| compInt | output | 1 | 1 = internal compensation, 0 = external |
| doutEn | output | 1 | Data-out gating, 0 while the output must shift zeros |
| convAbort | output | 1 | One-cycle pulse when the pin cancels a conversion |

## Verification
The assertions assume that `pinLow` and `pinHigh` are never both 1. They also assume that `convDone` is pulsed only while a conversion is running and that `reqValid` is a single-cycle pulse. The stimulus raises `convDone` only after it sees `converting` high, and it drives the pin flags from a three-valued pin setting. Requests are sent as isolated one-cycle pulses, including those sent on purpose during conversions, delays and shutdown. The bench compares every output on every cycle with a behavioural model, so the exact timing of each transition is checked.

// File: rtl/conv_pwr_pkg.sv
package conv_pwr_pkg;
  typedef enum logic [2:0] {
    S_POR, S_WAKE, S_IDLE, S_CONV, S_FAST, S_FULL, S_HWSD
  } pwrSt_t;

  typedef struct packed {
    logic loadTmr;   // start the wake-delay timer
    logic tmrFull;   // delay from full power-down (else fast)
    logic latchPd;   // capture the request's mode bits
    logic applyMode; // conversion starts: apply clock mode
    logic setValid;  // a conversion completed
  } ctlStrb_t;
endpackage

// File: rtl/conv_pwr_dp.sv
module conv_pwr_dp
  import conv_pwr_pkg::*;
#(
  parameter int CLK_PER_US   = 2,
  parameter int POR_US       = 100,
  parameter int FAST_WAKE_US = 5,
  parameter int FULL_WAKE_US = 300,
  parameter int EXT_WAKE_US  = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrb_t   strb,
  input  logic [1:0] reqPd,
  input  logic       pinLow,
  input  logic       pinHigh,
  output logic       shdnAct,
  output logic       compInt,
  output logic       tmrExpire,
  output logic [1:0] pdHeld,
  output logic       extClk,
  output logic       doutEn
);
  localparam int MaxA  = (POR_US > FULL_WAKE_US) ? POR_US : FULL_WAKE_US;
  localparam int MaxB  = (FAST_WAKE_US > EXT_WAKE_US) ? FAST_WAKE_US : EXT_WAKE_US;
  localparam int MaxUs = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int UsW   = $clog2(MaxUs + 1);
  localparam int PreW  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PreW-1:0] PreTop = PreW'(CLK_PER_US - 1);
  localparam logic [UsW-1:0]  PorVal  = UsW'(POR_US);
  localparam logic [UsW-1:0]  FastVal = UsW'(FAST_WAKE_US);
  localparam logic [UsW-1:0]  FullVal = UsW'(FULL_WAKE_US);
  localparam logic [UsW-1:0]  ExtVal  = UsW'(EXT_WAKE_US);

  // two-flop synchronisers for the pin flags
  logic [1:0] lowSync, highSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowSync  <= '0;
      highSync <= '0;
    end else begin
      lowSync  <= {lowSync[0], pinLow};
      highSync <= {highSync[0], pinHigh};
    end
  end
  assign shdnAct = lowSync[1];
  assign compInt = highSync[1];

  // microsecond delay timer
  logic [PreW-1:0] preCnt;
  logic [UsW-1:0]  usCnt;
  logic            tmrRun;
  logic [UsW-1:0]  loadVal;

  always_comb begin
    if (!compInt)          loadVal = ExtVal;
    else if (strb.tmrFull) loadVal = FullVal;
    else                   loadVal = FastVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= PreTop;
      usCnt     <= PorVal;
      tmrRun    <= 1'b1;
      tmrExpire <= 1'b0;
    end else begin
      tmrExpire <= 1'b0;
      if (shdnAct) begin
        tmrRun <= 1'b0;
      end else if (strb.loadTmr) begin
        preCnt <= PreTop;
        usCnt  <= loadVal;
        tmrRun <= 1'b1;
      end else if (tmrRun) begin
        if (preCnt == '0) begin
          preCnt <= PreTop;
          usCnt  <= usCnt - 1'b1;
          if (usCnt == UsW'(1)) begin
            tmrRun    <= 1'b0;
            tmrExpire <= 1'b1;
          end
        end else begin
          preCnt <= preCnt - 1'b1;
        end
      end
    end
  end

  // mode bits and clock mode
  logic [1:0] pdNext;
  assign pdNext = strb.latchPd ? reqPd : pdHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdHeld <= 2'b00;
      extClk <= 1'b0;
      doutEn <= 1'b0;
    end else begin
      if (strb.latchPd)                  pdHeld <= reqPd;
      if (strb.applyMode && pdNext[1])   extClk <= pdNext[0];
      if (strb.setValid)                 doutEn <= 1'b1;
    end
  end

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |=> doutEn);

  // R5
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyMode |=> $stable(extClk));
endmodule

// File: rtl/conv_pwr_fsm.sv
module conv_pwr_fsm
  import conv_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       convDone,
  input  logic       shdnAct,
  input  logic       tmrExpire,
  input  logic [1:0] pdHeld,
  output pwrSt_t     st,
  output logic       busy,
  output logic       convAbort,
  output ctlStrb_t   strb
);
  pwrSt_t stNext;
  logic   pendNext;

  always_comb begin
    strb     = '0;
    stNext   = st;
    pendNext = busy;
    if (shdnAct) begin
      stNext   = S_HWSD;
      pendNext = 1'b0;
    end else begin
      unique case (st)
        S_POR, S_WAKE: begin
          if (reqValid) begin
            strb.latchPd = 1'b1;
            pendNext     = 1'b1;
          end
          if (tmrExpire) begin
            pendNext = 1'b0;
            if (busy || reqValid) begin
              stNext         = S_CONV;
              strb.applyMode = 1'b1;
            end else begin
              stNext = S_IDLE;
            end
          end
        end
        S_IDLE: if (reqValid) begin
          strb.latchPd   = 1'b1;
          strb.applyMode = 1'b1;
          stNext         = S_CONV;
        end
        S_CONV: if (convDone) begin
          strb.setValid = 1'b1;
          if (pdHeld[1])      stNext = S_IDLE;
          else if (pdHeld[0]) stNext = S_FAST;
          else                stNext = S_FULL;
        end
        S_FAST, S_FULL: if (reqValid) begin
          strb.latchPd = 1'b1;
          strb.loadTmr = 1'b1;
          strb.tmrFull = (st == S_FULL);
          pendNext     = 1'b1;
          stNext       = S_WAKE;
        end
        S_HWSD: begin
          strb.loadTmr = 1'b1;
          strb.tmrFull = 1'b1;
          stNext       = S_WAKE;
        end
        default: stNext = S_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_POR;
      busy      <= 1'b0;
      convAbort <= 1'b0;
    end else begin
      st        <= stNext;
      busy      <= pendNext;
      convAbort <= shdnAct && (st == S_CONV);
    end
  end

  // R7
  shdn_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    shdnAct |=> (st == S_HWSD) && !busy);

  // R4
  pd_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CONV && convDone && !shdnAct && !pdHeld[1])
      |=> (st == S_FAST || st == S_FULL));

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st == S_POR || st == S_WAKE) && !tmrExpire) |=> (st != S_CONV));

  // R6
  wake_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WAKE && tmrExpire && busy && !shdnAct) |=> (st == S_CONV));
endmodule

// File: rtl/conv_pwr_ctrl.sv
module conv_pwr_ctrl
  import conv_pwr_pkg::*;
#(
  parameter int CLK_PER_US   = 2,
  parameter int POR_US       = 100,
  parameter int FAST_WAKE_US = 5,
  parameter int FULL_WAKE_US = 300,
  parameter int EXT_WAKE_US  = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPd,
  input  logic       convDone,
  input  logic       pinLow,
  input  logic       pinHigh,
  output logic       powerOn,
  output logic       fastDown,
  output logic       fullDown,
  output logic       wakeUp,
  output logic       busy,
  output logic       converting,
  output logic       convStrobe,
  output logic       extClk,
  output logic       compInt,
  output logic       doutEn,
  output logic       convAbort
);
  ctlStrb_t   strb;
  pwrSt_t     st;
  logic       shdnAct, tmrExpire;
  logic [1:0] pdHeld;

  conv_pwr_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .convDone(convDone),
    .shdnAct(shdnAct), .tmrExpire(tmrExpire), .pdHeld(pdHeld),
    .st(st), .busy(busy), .convAbort(convAbort), .strb(strb)
  );

  conv_pwr_dp #(
    .CLK_PER_US(CLK_PER_US), .POR_US(POR_US), .FAST_WAKE_US(FAST_WAKE_US),
    .FULL_WAKE_US(FULL_WAKE_US), .EXT_WAKE_US(EXT_WAKE_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqPd(reqPd),
    .pinLow(pinLow), .pinHigh(pinHigh), .shdnAct(shdnAct),
    .compInt(compInt), .tmrExpire(tmrExpire), .pdHeld(pdHeld),
    .extClk(extClk), .doutEn(doutEn)
  );

  assign powerOn    = (st == S_IDLE) || (st == S_CONV);
  assign fastDown   = (st == S_FAST);
  assign fullDown   = (st == S_FULL) || (st == S_HWSD);
  assign wakeUp     = (st == S_POR) || (st == S_WAKE);
  assign converting = (st == S_CONV);
  assign convStrobe = !converting;
endmodule

// File: tb/conv_pwr_ctrl_tb.sv
module conv_pwr_ctrl_tb_top;
  localparam int ClkPeriod = 10;
  localparam int Cpu  = 2;
  localparam int PorU = 100;
  localparam int FstU = 5;
  localparam int FulU = 300;
  localparam int ExtU = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqPd = 2'b00;
  logic convDone = 1'b0;
  logic pinLow = 1'b0;
  logic pinHigh = 1'b1;
  logic powerOn, fastDown, fullDown, wakeUp, busy, converting;
  logic convStrobe, extClk, compInt, doutEn, convAbort;

  always #(ClkPeriod/2) clk = ~clk;

  conv_pwr_ctrl #(
    .CLK_PER_US(Cpu), .POR_US(PorU), .FAST_WAKE_US(FstU),
    .FULL_WAKE_US(FulU), .EXT_WAKE_US(ExtU)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPd(reqPd),
    .convDone(convDone), .pinLow(pinLow), .pinHigh(pinHigh),
    .powerOn(powerOn), .fastDown(fastDown), .fullDown(fullDown),
    .wakeUp(wakeUp), .busy(busy), .converting(converting),
    .convStrobe(convStrobe), .extClk(extClk), .compInt(compInt),
    .doutEn(doutEn), .convAbort(convAbort)
  );

  int vecs = 0;
  int miss = 0;
  bit finished = 0;

  // behavioural model: 0 por,1 wake,2 idle,3 conv,4 fast,5 full,6 pin-off
  int mSt, mCnt;
  bit mPend, mExt, mDv, mAbort;
  bit [1:0] mPd;
  bit sL1, sL2, sH1, sH2;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCnt = PorU * Cpu; mPend = 0; mPd = 0; mExt = 0;
      mDv = 0; mAbort = 0; sL1 = 0; sL2 = 0; sH1 = 0; sH2 = 0;
    end else begin
      mAbort = 0;
      if (sL2) begin
        if (mSt == 3) mAbort = 1;
        mSt = 6; mPend = 0;
      end else begin
        case (mSt)
          0, 1: begin
            if (reqValid) begin mPd = reqPd; mPend = 1; end
            if (mCnt == 0) begin
              if (mPend) begin
                mSt = 3; mPend = 0;
                if (mPd[1]) mExt = mPd[0];
              end else mSt = 2;
            end else mCnt = mCnt - 1;
          end
          2: if (reqValid) begin
            mPd = reqPd; mSt = 3;
            if (mPd[1]) mExt = mPd[0];
          end
          3: if (convDone) begin
            mDv = 1;
            mSt = mPd[1] ? 2 : (mPd[0] ? 4 : 5);
          end
          4, 5: if (reqValid) begin
            mPd = reqPd; mPend = 1;
            mCnt = (sH2 ? ((mSt == 5) ? FulU : FstU) : ExtU) * Cpu;
            mSt = 1;
          end
          default: begin
            mSt = 1; mCnt = (sH2 ? FulU : ExtU) * Cpu;
          end
        endcase
      end
      sL2 = sL1; sL1 = pinLow; sH2 = sH1; sH1 = pinHigh;
    end
  end

  task automatic chk(string what, string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("powerOn",    "R4", powerOn,    mSt == 2 || mSt == 3);
      chk("fastDown",   "R4", fastDown,   mSt == 4);
      chk("fullDown",   "R7 R9", fullDown, mSt == 5 || mSt == 6);
      chk("wakeUp",     "R2 R6", wakeUp,  mSt == 0 || mSt == 1);
      chk("busy",       "R6", busy,       mPend);
      chk("converting", "R2", converting, mSt == 3);
      chk("convStrobe", "R1", convStrobe, mSt != 3);
      chk("extClk",     "R5", extClk,     mExt);
      chk("compInt",    "R8", compInt,    sH2);
      chk("doutEn",     "R3", doutEn,     mDv);
      chk("convAbort",  "R7", convAbort,  mAbort);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sendReq(logic [1:0] pd);
    cyc(1); reqValid = 1'b1; reqPd = pd;
    cyc(1); reqValid = 1'b0;
  endtask

  task automatic finishConv(int lat);
    for (int i = 0; i < 3000 && !converting; i++) cyc(1);
    cyc(lat); convDone = 1'b1;
    cyc(1); convDone = 1'b0;
  endtask

  // pin: 0 low, 1 high, 2 floating
  task automatic setPin(int v);
    cyc(1);
    pinLow = (v == 0); pinHigh = (v == 1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state, checked directly as well as by the model
    chk("reset wakeUp", "R1", wakeUp, 1'b1);
    chk("reset extClk", "R1", extClk, 1'b0);
    chk("reset strobe", "R1", convStrobe, 1'b1);
    chk("reset busy",   "R1", busy, 1'b0);
    chk("reset dout",   "R3", doutEn, 1'b0);
    // R2 request held during power-on interval, external clock kept on
    cyc(40); sendReq(2'b11);
    chk("held request", "R2", busy, 1'b1);
    finishConv(6);
    cyc(3);
    chk("ext clock",    "R4", extClk, 1'b1);
    chk("data valid",   "R3", doutEn, 1'b1);
    // R5 internal clock stay-on, second request during conversion ignored
    sendReq(2'b10); cyc(2); sendReq(2'b00); cyc(2);
    chk("ignored req", "R5", converting, 1'b1);
    finishConv(3); cyc(3);
    chk("back idle", "R4", powerOn, 1'b1);
    // R6 fast power-down, internal compensation wake
    sendReq(2'b01); finishConv(4); cyc(3);
    chk("in fast", "R4", fastDown, 1'b1);
    sendReq(2'b11); finishConv(2); cyc(3);
    // full power-down, internal compensation wake
    sendReq(2'b00); finishConv(2); cyc(3);
    chk("in full", "R4", fullDown, 1'b1);
    sendReq(2'b10); finishConv(2); cyc(3);
    // R8 floating pin: external compensation wake from fast
    setPin(2); cyc(4);
    chk("float comp", "R8", compInt, 1'b0);
    sendReq(2'b01); finishConv(2); cyc(3);
    sendReq(2'b11); finishConv(2); cyc(3);
    // R7 pin low aborts a running conversion; R9 release
    setPin(1); cyc(4);
    sendReq(2'b11); cyc(3);
    setPin(0); cyc(2); sendReq(2'b10); cyc(4);
    chk("pin off", "R7", fullDown, 1'b1);
    setPin(1);
    for (int i = 0; i < 1000 && !powerOn; i++) cyc(1);
    chk("release idle", "R9", powerOn, 1'b1);
    // pin low during a wake delay, then a conversion after release
    sendReq(2'b00); finishConv(2); cyc(3);
    sendReq(2'b10); cyc(20);
    setPin(0); cyc(6); setPin(2);
    for (int i = 0; i < 1500 && !powerOn; i++) cyc(1);
    sendReq(2'b11); finishConv(1); cyc(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miss++; vecs++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule